// File: doc/BRIEF.md
# Debug Breakpoint Register Access Trap Arbiter

This block decides the fate of every attempted read or write of a debug breakpoint value register. Each request arrives with the current privilege level and a snapshot of the system configuration. This snapshot covers which higher levels exist or are enabled, which execution width they use, their debug trap controls, the OS lock state, whether halting is permitted, and the external debugger's trap bit. From these the arbiter picks exactly one outcome. The access may complete, be undefined, trap to the hypervisor level (wide-state or narrow-state style), trap to the monitor level, or raise a debug halt.

The outcome leaves the block one cycle after the request as a one-hot vector, together with an exception class code, the request's register index and its direction. The checks run in a fixed priority that depends on the privilege level. A higher-priority check hides every check below it. Reading and writing the register itself is left to the surrounding logic, which acts on a completed outcome by using the echoed index.

Top module: `dbg_access_arbiter`

## Requirements
- R1: A valid request at privilege level 0 (`cur_level` = 2'd0) yields outcome bit 1 (undefined), whatever the other inputs are.
- R2: At level 1, the wide-state hypervisor trap (bit 2) wins when `hyp_enabled` is 1, `hyp_narrow` is 0 and `hyp_trap_pair` is nonzero, ahead of every other check.
- R3: At level 1, when R2 does not fire, the narrow-state hypervisor trap (bit 3) wins when `hyp_enabled` is 1, `hyp_narrow` is 1 and `hyp_trap_pair` is nonzero.
- R4: The monitor trap (bit 4) fires when `mon_present` is 1, `mon_narrow` is 0 and `mon_trap_bit` is 1. It is the third check at level 1 and the first check at level 2, and it is never taken at level 3.
- R5: The debug halt (bit 5) is the last check at levels 1, 2 and 3, and the only check at level 3. It fires when `k_narrow` is 1, `os_lock` is 0, `halt_ok` is 1 and `ext_trap_bit` is 1.
- R6: When no check fires at levels 1 to 3, the outcome is bit 0 (complete), and `resp_index` carries the request's 4-bit breakpoint index.
- R7: `resp_class` is 6'h05 for the three trap outcomes (bits 2, 3, 4) and 6'h00 for complete, undefined and halt.
- R8: The response appears exactly one clock after the request: `resp_valid` equals the previous cycle's `req_valid`, and `resp_outcome` and `resp_class` are zero when `resp_valid` is 0.
- R9: The decision does not depend on `req_write`. The direction is echoed on `resp_write`.
- R10: After synchronous reset, `resp_valid`, `resp_outcome` and `resp_class` are all zero.
- R11: Whenever `resp_valid` is 1, exactly one bit of `resp_outcome` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access attempt this cycle |
| req_write | input | 1 | 1 = write form, 0 = read form |
| req_index | input | 4 | Breakpoint register index |
| cur_level | input | 2 | Current privilege level 0..3 |
| hyp_enabled | input | 1 | Hypervisor level enabled in current security state |
| hyp_narrow | input | 1 | Hypervisor level uses 32-bit state |
| hyp_trap_pair | input | 2 | Hypervisor debug trap control pair |
| mon_present | input | 1 | Monitor level implemented |
| mon_narrow | input | 1 | Monitor level uses 32-bit state |
| mon_trap_bit | input | 1 | Monitor debug-access trap enable |
| k_narrow | input | 1 | Level 1 uses 32-bit state |
| os_lock | input | 1 | OS lock set |
| halt_ok | input | 1 | Halting currently allowed |
| ext_trap_bit | input | 1 | External debugger trap-access enable |
| resp_valid | output | 1 | Decision valid |
| resp_write | output | 1 | Echoed direction |
| resp_index | output | 4 | Echoed index |
| resp_outcome | output | 6 | One-hot: 0 complete, 1 undefined, 2 hyp wide trap, 3 hyp narrow trap, 4 monitor trap, 5 halt |
| resp_class | output | 6 | Exception class code |

## Verification
The assertions assume that the configuration inputs are stable during the request cycle and meaningful only when `req_valid` is high. They also assume that `cur_level` always holds one of the four defined levels. The stimulus drives all inputs as a single bundle on the falling edge and keeps them for the whole cycle. Flags are drawn from biased random values so that each check, alone or shadowed by a higher one, shows up often. Directed cases pin the shadowing corners, such as a level 1 request with every trap armed and a level 3 request with only the monitor trap armed.

// File: rtl/dbg_trap_pkg.sv
package dbg_trap_pkg;

    localparam int LVL_W      = 2;
    localparam int OUTC_N     = 6;
    localparam int CLASS_W    = 6;
    localparam logic [CLASS_W-1:0] TRAP_CLASS = 6'h05;

    // outcome bit positions
    localparam int OC_DONE  = 0;
    localparam int OC_UNDEF = 1;
    localparam int OC_HYPW  = 2;
    localparam int OC_HYPN  = 3;
    localparam int OC_MON   = 4;
    localparam int OC_HALT  = 5;

    typedef logic [OUTC_N-1:0] outcome_t;

    typedef enum logic [LVL_W-1:0] {
        LVL_USER   = 2'd0,
        LVL_KERNEL = 2'd1,
        LVL_HYPER  = 2'd2,
        LVL_MONTR  = 2'd3
    } priv_lvl_e;

    typedef struct packed {
        logic hyp_wide;
        logic hyp_narrow;
        logic mon;
        logic halt;
    } trap_hits_t;

    function automatic outcome_t one_bit(input int pos);
        outcome_t v;
        v = '0;
        v[pos] = 1'b1;
        return v;
    endfunction

    // priority walk for one privilege level
    function automatic outcome_t resolve(input priv_lvl_e lvl, input trap_hits_t h);
        outcome_t r;
        unique case (lvl)
            LVL_USER:   r = one_bit(OC_UNDEF);
            LVL_KERNEL: begin
                if      (h.hyp_wide)   r = one_bit(OC_HYPW);
                else if (h.hyp_narrow) r = one_bit(OC_HYPN);
                else if (h.mon)        r = one_bit(OC_MON);
                else if (h.halt)       r = one_bit(OC_HALT);
                else                   r = one_bit(OC_DONE);
            end
            LVL_HYPER: begin
                if      (h.mon)        r = one_bit(OC_MON);
                else if (h.halt)       r = one_bit(OC_HALT);
                else                   r = one_bit(OC_DONE);
            end
            default: begin
                if (h.halt)            r = one_bit(OC_HALT);
                else                   r = one_bit(OC_DONE);
            end
        endcase
        return r;
    endfunction

    function automatic logic is_trap(input outcome_t o);
        return o[OC_HYPW] | o[OC_HYPN] | o[OC_MON];
    endfunction

endpackage

// File: rtl/dbg_trap_checks.sv
module dbg_trap_checks
    import dbg_trap_pkg::*;
(
    input  logic       hyp_enabled,
    input  logic       hyp_narrow,
    input  logic [1:0] hyp_trap_pair,
    input  logic       mon_present,
    input  logic       mon_narrow,
    input  logic       mon_trap_bit,
    input  logic       k_narrow,
    input  logic       os_lock,
    input  logic       halt_ok,
    input  logic       ext_trap_bit,
    output trap_hits_t hits
);
    logic hyp_armed;

    always_comb begin
        hyp_armed       = hyp_enabled && (hyp_trap_pair != 2'b00);
        hits.hyp_wide   = hyp_armed && !hyp_narrow;
        hits.hyp_narrow = hyp_armed && hyp_narrow;
        hits.mon        = mon_present && !mon_narrow && mon_trap_bit;
        hits.halt       = k_narrow && !os_lock && halt_ok && ext_trap_bit;
    end
endmodule

// File: rtl/dbg_trap_select.sv
module dbg_trap_select
    import dbg_trap_pkg::*;
#(
    parameter int NUM_LVL = 4
) (
    input  logic [LVL_W-1:0]   cur_level,
    input  trap_hits_t         hits,
    output outcome_t           outcome,
    output logic [CLASS_W-1:0] exc_class
);
    outcome_t per_lvl [NUM_LVL];

    for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl
        always_comb per_lvl[g] = resolve(priv_lvl_e'(g), hits);
    end

    always_comb begin
        outcome   = per_lvl[cur_level];
        exc_class = is_trap(outcome) ? TRAP_CLASS : '0;
    end
endmodule

// File: rtl/dbg_access_arbiter.sv
module dbg_access_arbiter
    import dbg_trap_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [IDX_W-1:0]    req_index,
    input  logic [LVL_W-1:0]    cur_level,
    input  logic                hyp_enabled,
    input  logic                hyp_narrow,
    input  logic [1:0]          hyp_trap_pair,
    input  logic                mon_present,
    input  logic                mon_narrow,
    input  logic                mon_trap_bit,
    input  logic                k_narrow,
    input  logic                os_lock,
    input  logic                halt_ok,
    input  logic                ext_trap_bit,
    output logic                resp_valid,
    output logic                resp_write,
    output logic [IDX_W-1:0]    resp_index,
    output logic [OUTC_N-1:0]   resp_outcome,
    output logic [CLASS_W-1:0]  resp_class
);
    trap_hits_t         hits;
    outcome_t           dec_outcome;
    logic [CLASS_W-1:0] dec_class;

    dbg_trap_checks u_checks (
        .hyp_enabled  (hyp_enabled),
        .hyp_narrow   (hyp_narrow),
        .hyp_trap_pair(hyp_trap_pair),
        .mon_present  (mon_present),
        .mon_narrow   (mon_narrow),
        .mon_trap_bit (mon_trap_bit),
        .k_narrow     (k_narrow),
        .os_lock      (os_lock),
        .halt_ok      (halt_ok),
        .ext_trap_bit (ext_trap_bit),
        .hits         (hits)
    );

    dbg_trap_select #(.NUM_LVL(1 << LVL_W)) u_select (
        .cur_level(cur_level),
        .hits     (hits),
        .outcome  (dec_outcome),
        .exc_class(dec_class)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_valid   <= 1'b0;
            resp_write   <= 1'b0;
            resp_index   <= '0;
            resp_outcome <= '0;
            resp_class   <= '0;
        end else begin
            resp_valid   <= req_valid;
            resp_write   <= req_write;
            resp_index   <= req_index;
            resp_outcome <= req_valid ? dec_outcome : '0;
            resp_class   <= req_valid ? dec_class : '0;
        end
    end

    // R11: exactly one outcome per valid response, none otherwise
    assert_onehot_R11: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> $countones(resp_outcome) == 1);
    assert_idle_R8: assert property (@(posedge clk) disable iff (rst)
        !resp_valid |-> (resp_outcome == '0 && resp_class == '0));
    assert_latency_R8: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> resp_valid);
    assert_user_undef_R1: assert property (@(posedge clk) disable iff (rst)
        (req_valid && cur_level == 2'd0) |=> resp_outcome[OC_UNDEF]);
    assert_class_R7: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> ((resp_class == TRAP_CLASS) ==
            (resp_outcome[OC_HYPW] || resp_outcome[OC_HYPN] || resp_outcome[OC_MON])));
    assert_top_no_mon_R4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && cur_level == 2'd3) |=> !resp_outcome[OC_MON]);
    assert_halt_cond_R5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !(k_narrow && !os_lock && halt_ok && ext_trap_bit))
            |=> !resp_outcome[OC_HALT]);
endmodule

// File: tb/dbg_access_arbiter_tb.sv
`timescale 1ns/1ps
module dbg_access_arbiter_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 0, req_write = 0;
    logic [3:0] req_index = 0;
    logic [1:0] cur_level = 0;
    logic       hyp_enabled = 0, hyp_narrow = 0;
    logic [1:0] hyp_trap_pair = 0;
    logic       mon_present = 0, mon_narrow = 0, mon_trap_bit = 0;
    logic       k_narrow = 0, os_lock = 0, halt_ok = 0, ext_trap_bit = 0;
    logic       resp_valid, resp_write;
    logic [3:0] resp_index;
    logic [5:0] resp_outcome, resp_class;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    dbg_access_arbiter u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_index(req_index), .cur_level(cur_level),
        .hyp_enabled(hyp_enabled), .hyp_narrow(hyp_narrow), .hyp_trap_pair(hyp_trap_pair),
        .mon_present(mon_present), .mon_narrow(mon_narrow), .mon_trap_bit(mon_trap_bit),
        .k_narrow(k_narrow), .os_lock(os_lock), .halt_ok(halt_ok), .ext_trap_bit(ext_trap_bit),
        .resp_valid(resp_valid), .resp_write(resp_write), .resp_index(resp_index),
        .resp_outcome(resp_outcome), .resp_class(resp_class)
    );

    // reference model written from the requirements
    function automatic logic [5:0] ref_outcome();
        logic hw, hn, mn, hl;
        hw = hyp_enabled && !hyp_narrow && hyp_trap_pair != 0;
        hn = hyp_enabled && hyp_narrow && hyp_trap_pair != 0;
        mn = mon_present && !mon_narrow && mon_trap_bit;
        hl = k_narrow && !os_lock && halt_ok && ext_trap_bit;
        if (cur_level == 0) return 6'b000010;
        if (cur_level == 1 && hw) return 6'b000100;
        if (cur_level == 1 && hn) return 6'b001000;
        if (cur_level != 3 && mn) return 6'b010000;
        if (hl) return 6'b100000;
        return 6'b000001;
    endfunction

    function automatic string tag_of(input logic [5:0] o);
        case (o)
            6'b000010: return "R1";
            6'b000100: return "R2";
            6'b001000: return "R3";
            6'b010000: return "R4";
            6'b100000: return "R5";
            default:   return "R6";
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // drive at negedge, check after the capturing posedge
    task automatic issue(input logic v);
        logic [5:0] exp_o;
        logic [5:0] exp_c;
        @(negedge clk);
        req_valid = v;
        exp_o = v ? ref_outcome() : 6'b0;
        exp_c = (exp_o[2] | exp_o[3] | exp_o[4]) ? 6'h05 : 6'h00;
        @(posedge clk);
        #1;
        check(v ? tag_of(exp_o) : "R8", {26'b0, resp_outcome}, {26'b0, exp_o});
        check("R7", {26'b0, resp_class}, {26'b0, exp_c});
        check("R8", {31'b0, resp_valid}, {31'b0, v});
        if (v) begin
            check("R6", {28'b0, resp_index}, {28'b0, req_index});
            check("R9", {31'b0, resp_write}, {31'b0, req_write});
        end
    endtask

    task automatic set_cfg(input logic [1:0] lvl, input logic he, hnw, input logic [1:0] hp,
                           input logic mp, mnw, mt, kn, ol, ho, et);
        @(negedge clk);
        cur_level = lvl; hyp_enabled = he; hyp_narrow = hnw; hyp_trap_pair = hp;
        mon_present = mp; mon_narrow = mnw; mon_trap_bit = mt;
        k_narrow = kn; os_lock = ol; halt_ok = ho; ext_trap_bit = et;
    endtask

    initial begin : watchdog
        #400000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        repeat (3) @(posedge clk);
        #1;
        check("R10", {31'b0, resp_valid}, 32'd0);
        check("R10", {26'b0, resp_outcome}, 32'd0);
        check("R10", {26'b0, resp_class}, 32'd0);
        @(negedge clk);
        rst = 1'b0;

        // directed corners
        set_cfg(2'd0, 1,0,2'b11, 1,0,1, 1,0,1,1); issue(1);   // R1 with all armed
        set_cfg(2'd1, 1,0,2'b01, 1,0,1, 1,0,1,1); issue(1);   // R2 shadows all
        set_cfg(2'd1, 1,1,2'b10, 1,0,1, 1,0,1,1); issue(1);   // R3
        set_cfg(2'd1, 1,0,2'b00, 1,0,1, 1,0,1,1); issue(1);   // R4 at level 1
        set_cfg(2'd2, 1,0,2'b11, 1,0,1, 1,0,1,1); issue(1);   // R4 first at level 2
        set_cfg(2'd3, 1,0,2'b11, 1,0,1, 0,0,1,1); issue(1);   // R4 not at level 3 -> R6
        set_cfg(2'd3, 0,0,2'b00, 0,0,0, 1,0,1,1); issue(1);   // R5 at level 3
        set_cfg(2'd2, 0,0,2'b00, 1,1,1, 1,1,1,1); issue(1);   // R6 os lock blocks halt
        req_write = 1; req_index = 4'hF;
        set_cfg(2'd1, 1,1,2'b11, 0,0,0, 0,0,0,0); issue(1);   // R9 write form, R3
        issue(0);                                              // R8 idle

        // random mix
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            req_write     = 1'($urandom);
            req_index     = 4'($urandom);
            cur_level     = 2'($urandom);
            hyp_enabled   = 1'($urandom);
            hyp_narrow    = 1'($urandom);
            hyp_trap_pair = ($urandom % 3 == 0) ? 2'($urandom) : 2'b00;
            mon_present   = 1'($urandom);
            mon_narrow    = ($urandom % 4 == 0);
            mon_trap_bit  = 1'($urandom);
            k_narrow      = ($urandom % 4 != 0);
            os_lock       = ($urandom % 4 == 0);
            halt_ok       = ($urandom % 4 != 0);
            ext_trap_bit  = 1'($urandom);
            issue(($urandom % 8) != 0);
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule